// File: doc/BRIEF.md
# Tag-Renamed Reservation Station Bank

This block is a small pool of reservation stations combined with a register rename table, for dynamic out-of-order scheduling. An instruction offered on the issue port is placed in the lowest-numbered free station. Each of its two source operands is resolved in one of two ways. If the register has no pending producer, the operand is the register's current value. If it has one, the operand is the tag of the station that will produce it. The destination register is then renamed to the new station's tag. Write-after-read and write-after-write hazards therefore never stall issue. Issue stalls only when every station is occupied.

A single shared result bus carries a value together with the tag of the station that produced it. Every station watches this bus. A station waiting on the broadcast tag captures the value. The register whose rename entry still holds that tag takes the value and drops the rename. The producing station becomes free again. A station whose two operands are both present is sent to execution once, through a registered dispatch port, and lower-numbered stations go first. A debug read port exposes the value and rename tag of any register.

Top module: `rsv_bank`

## Requirements
- R1: After reset every station is free (`iss_ready`=1), no dispatch is presented, and every register reads value 0 with rename tag 0.
- R2: An accepted issue (`iss_valid` with `iss_ready`) occupies the lowest-indexed free station. Station i carries tag i+1, and tag 0 means "no producer". The destination register's rename tag becomes that station's tag on the next cycle.
- R3: `iss_ready` is low exactly when all stations are occupied. An issue offered then is ignored and leaves the rename table unchanged.
- R4: At issue, a source whose rename tag is 0 is captured as the register's value. Otherwise the station records the rename tag and waits.
- R5: When an issue coincides with a bus broadcast whose tag equals a source's rename tag, the station takes the broadcast value directly and does not wait.
- R6: A waiting station whose pending tag equals the broadcast tag captures the broadcast value and stops waiting.
- R7: A broadcast writes a register only if that register's rename tag equals the broadcast tag, and then clears the tag. After two renames of the same register, the older producer's result does not reach it.
- R8: A station with both operands present is dispatched exactly once. `disp_valid`, `disp_tag`, `disp_op` and both operand values appear one cycle after it became ready. When several stations are ready, the lowest index goes first, one per cycle.
- R9: A broadcast carrying a station's tag frees that station, and the station can be reissued on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code carried with the instruction |
| iss_dst | input | log2(NUM_REGS) | Destination register |
| iss_src_a | input | log2(NUM_REGS) | First source register |
| iss_src_b | input | log2(NUM_REGS) | Second source register |
| iss_ready | output | 1 | A free station exists |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the producing station |
| cdb_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | Dispatch to execution this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched station |
| disp_op | output | OP_W | Operation of the dispatched station |
| disp_va | output | DATA_W | First operand value |
| disp_vb | output | DATA_W | Second operand value |
| dbg_addr | input | log2(NUM_REGS) | Register selected for inspection |
| dbg_val | output | DATA_W | Value of the selected register |
| dbg_tag | output | TAG_W | Rename tag of the selected register |

## Verification
A vector sequence drives a dependent chain through the bank. An independent instruction dispatches at once. A consumer waits on a tag and wakes by snooping. A station is reused after it is freed. An issue meets a broadcast in the same cycle. The sequence ends with two stations ready together, which separates correct lowest-index ordering and once-only dispatch from duplicate or reordered dispatch. Directed tests then rename one register twice and broadcast the older result first, which shows whether writeback is gated by the rename tag. They also fill every station and offer one more issue, which shows whether a full bank really ignores it and frees a slot on broadcast.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  // How a source operand is obtained at issue time
  typedef enum logic [1:0] {
    SRC_REG    = 2'd0,  // no producer pending: register value
    SRC_BYPASS = 2'd1,  // producer broadcasting this very cycle
    SRC_WAIT   = 2'd2   // producer pending: hold its tag
  } src_kind_e;
endpackage

// File: rtl/rsv_pick.sv
module rsv_pick #(
  parameter int N  = 4,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic found;

  always_comb begin
    gnt   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        idx    = IW'(i);
        found  = 1'b1;
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/rsv_rename.sv
module rsv_rename #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  localparam int RA_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   rd_a_addr,
  input  logic [RA_W-1:0]   rd_b_addr,
  input  logic [RA_W-1:0]   dbg_addr,
  output logic [DATA_W-1:0] rd_a_val,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [DATA_W-1:0] rd_b_val,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [DATA_W-1:0] dbg_val,
  output logic [TAG_W-1:0]  dbg_tag,
  input  logic              ren_we,
  input  logic [RA_W-1:0]   ren_dst,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  logic [DATA_W-1:0] val_q [NUM_REGS];
  logic [TAG_W-1:0]  tag_q [NUM_REGS];

  // Broadcast writes every register still naming the producer; a rename
  // issued in the same cycle takes precedence for the tag.
  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rst) begin
        val_q[r] <= '0;
        tag_q[r] <= '0;
      end else begin
        if (cdb_valid && cdb_tag != '0 && tag_q[r] == cdb_tag) begin
          val_q[r] <= cdb_data;
          tag_q[r] <= '0;
        end
        if (ren_we && ren_dst == RA_W'(r))
          tag_q[r] <= ren_tag;
      end
    end
  end

  assign rd_a_val = val_q[rd_a_addr];
  assign rd_a_tag = tag_q[rd_a_addr];
  assign rd_b_val = val_q[rd_b_addr];
  assign rd_b_tag = tag_q[rd_b_addr];
  assign dbg_val  = val_q[dbg_addr];
  assign dbg_tag  = tag_q[dbg_addr];

  assert_rename_set_R2: assert property (@(posedge clk) disable iff (rst)
    ren_we |=> tag_q[$past(ren_dst)] == $past(ren_tag));
endmodule

// File: rtl/rsv_station.sv
module rsv_station #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   op_in,
  input  logic [DATA_W-1:0] a_val,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] b_val,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              dispatch,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] va,
  output logic [DATA_W-1:0] vb
);
  logic             busy_q, exec_q;
  logic [TAG_W-1:0] qa_q, qb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      exec_q <= 1'b0;
      qa_q   <= '0;
      qb_q   <= '0;
      op     <= '0;
      va     <= '0;
      vb     <= '0;
    end else if (alloc) begin
      busy_q <= 1'b1;
      exec_q <= 1'b0;
      op     <= op_in;
      va     <= a_val;
      qa_q   <= a_tag;
      vb     <= b_val;
      qb_q   <= b_tag;
    end else if (busy_q) begin
      if (cdb_valid && qa_q != '0 && qa_q == cdb_tag) begin
        va   <= cdb_data;
        qa_q <= '0;
      end
      if (cdb_valid && qb_q != '0 && qb_q == cdb_tag) begin
        vb   <= cdb_data;
        qb_q <= '0;
      end
      if (dispatch)
        exec_q <= 1'b1;
      if (cdb_valid && cdb_tag == MY_TAG) begin
        busy_q <= 1'b0;
        exec_q <= 1'b0;
      end
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q && !exec_q && qa_q == '0 && qb_q == '0;

  assert_snoop_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !alloc && cdb_valid && qa_q != '0 && qa_q == cdb_tag)
      |=> (qa_q == '0 && va == $past(cdb_data)));

  assert_free_on_broadcast_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cdb_valid && cdb_tag == MY_TAG) |=> !busy_q);
endmodule

// File: rtl/rsv_bank.sv
module rsv_bank
  import rsv_pkg::*;
#(
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int OP_W     = 4,
  localparam int TAG_W   = $clog2(NUM_RS + 1),
  localparam int RA_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [RA_W-1:0]   iss_dst,
  input  logic [RA_W-1:0]   iss_src_a,
  input  logic [RA_W-1:0]   iss_src_b,
  output logic              iss_ready,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              disp_valid,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_va,
  output logic [DATA_W-1:0] disp_vb,
  input  logic [RA_W-1:0]   dbg_addr,
  output logic [DATA_W-1:0] dbg_val,
  output logic [TAG_W-1:0]  dbg_tag
);
  logic [NUM_RS-1:0] busy_vec, ready_vec, alloc_gnt, disp_gnt;
  logic [TAG_W-1:0]  alloc_idx, disp_idx;
  logic              free_any, disp_any, iss_fire;
  logic [OP_W-1:0]   st_op [NUM_RS];
  logic [DATA_W-1:0] st_va [NUM_RS];
  logic [DATA_W-1:0] st_vb [NUM_RS];

  logic [DATA_W-1:0] ra_val, rb_val, a_val, b_val;
  logic [TAG_W-1:0]  ra_tag, rb_tag, a_tag, b_tag;
  src_kind_e         a_kind, b_kind;

  rsv_rename #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ren (
    .clk(clk), .rst(rst),
    .rd_a_addr(iss_src_a), .rd_b_addr(iss_src_b), .dbg_addr(dbg_addr),
    .rd_a_val(ra_val), .rd_a_tag(ra_tag), .rd_b_val(rb_val), .rd_b_tag(rb_tag),
    .dbg_val(dbg_val), .dbg_tag(dbg_tag),
    .ren_we(iss_fire), .ren_dst(iss_dst), .ren_tag(alloc_idx + TAG_W'(1)),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
  );

  function automatic src_kind_e classify(input logic [TAG_W-1:0] t);
    if (t == '0)                     return SRC_REG;
    else if (cdb_valid && cdb_tag == t) return SRC_BYPASS;
    else                             return SRC_WAIT;
  endfunction

  always_comb begin
    a_kind = classify(ra_tag);
    b_kind = classify(rb_tag);
    a_val  = (a_kind == SRC_BYPASS) ? cdb_data : ra_val;
    b_val  = (b_kind == SRC_BYPASS) ? cdb_data : rb_val;
    a_tag  = (a_kind == SRC_WAIT) ? ra_tag : '0;
    b_tag  = (b_kind == SRC_WAIT) ? rb_tag : '0;
  end

  rsv_pick #(.N(NUM_RS), .IW(TAG_W)) u_alloc (
    .req(~busy_vec), .gnt(alloc_gnt), .idx(alloc_idx), .any(free_any));
  rsv_pick #(.N(NUM_RS), .IW(TAG_W)) u_disp (
    .req(ready_vec), .gnt(disp_gnt), .idx(disp_idx), .any(disp_any));

  assign iss_ready = free_any;
  assign iss_fire  = iss_valid && free_any;

  for (genvar i = 0; i < NUM_RS; i++) begin : g_st
    rsv_station #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W),
                  .MY_TAG(TAG_W'(i + 1))) u_st (
      .clk(clk), .rst(rst),
      .alloc(iss_fire && alloc_gnt[i]), .op_in(iss_op),
      .a_val(a_val), .a_tag(a_tag), .b_val(b_val), .b_tag(b_tag),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .dispatch(disp_gnt[i]),
      .busy(busy_vec[i]), .ready(ready_vec[i]),
      .op(st_op[i]), .va(st_va[i]), .vb(st_vb[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_tag   <= '0;
      disp_op    <= '0;
      disp_va    <= '0;
      disp_vb    <= '0;
    end else begin
      disp_valid <= disp_any;
      disp_tag   <= disp_any ? disp_idx + TAG_W'(1) : '0;
      disp_op    <= st_op[disp_idx];
      disp_va    <= st_va[disp_idx];
      disp_vb    <= st_vb[disp_idx];
    end
  end

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready && !cdb_valid) |=> $stable(busy_vec));

  assert_issue_fills_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_ready && !cdb_valid)
      |=> $countones(busy_vec) == $countones($past(busy_vec)) + 1);

  assert_one_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> disp_tag != '0);
endmodule

// File: tb/rsv_bank_test.sv
module rsv_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic        iv;
    logic [3:0]  op;
    logic [3:0]  dst;
    logic [3:0]  sa;
    logic [3:0]  sb;
    logic        cv;
    logic [2:0]  ct;
    logic [15:0] cd;
    logic        edv;
    logic [2:0]  etag;
    logic [3:0]  eop;
    logic [15:0] eva;
    logic [15:0] evb;
  } vec_t;

  // Dependent chain: snoop wake-up, station reuse, issue/broadcast bypass,
  // then two simultaneously ready stations (lowest index first, once each).
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd1, 4'd1, 4'd2, 4'd3, 1'b0, 3'd0, 16'h0,    1'b0, 3'd0, 4'd0, 16'h0,    16'h0},
    '{1'b1, 4'd2, 4'd4, 4'd1, 4'd5, 1'b0, 3'd0, 16'h0,    1'b1, 3'd1, 4'd1, 16'h0,    16'h0},
    '{1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1, 3'd1, 16'h0011, 1'b0, 3'd0, 4'd0, 16'h0,    16'h0},
    '{1'b1, 4'd3, 4'd6, 4'd1, 4'd4, 1'b0, 3'd0, 16'h0,    1'b1, 3'd2, 4'd2, 16'h0011, 16'h0},
    '{1'b1, 4'd4, 4'd7, 4'd4, 4'd1, 1'b1, 3'd2, 16'h0022, 1'b0, 3'd0, 4'd0, 16'h0,    16'h0},
    '{1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 3'd0, 16'h0,    1'b1, 3'd1, 4'd3, 16'h0011, 16'h0022},
    '{1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 3'd0, 16'h0,    1'b1, 3'd3, 4'd4, 16'h0022, 16'h0011},
    '{1'b0, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 3'd0, 16'h0,    1'b0, 3'd0, 4'd0, 16'h0,    16'h0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid;
  logic [3:0]  iss_op, iss_dst, iss_src_a, iss_src_b;
  logic        iss_ready;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [31:0] cdb_data;
  logic        disp_valid;
  logic [2:0]  disp_tag;
  logic [3:0]  disp_op;
  logic [31:0] disp_va, disp_vb;
  logic [3:0]  dbg_addr;
  logic [31:0] dbg_val;
  logic [2:0]  dbg_tag;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rsv_bank uut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_ready(iss_ready),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
    .disp_va(disp_va), .disp_vb(disp_vb),
    .dbg_addr(dbg_addr), .dbg_val(dbg_val), .dbg_tag(dbg_tag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    iss_valid = 1'b0; iss_op = '0; iss_dst = '0; iss_src_a = '0; iss_src_b = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] dst);
    iss_valid = 1'b1; iss_op = op; iss_dst = dst; iss_src_a = '0; iss_src_b = '0;
    step();
    idle_inputs();
  endtask

  task automatic broadcast(input logic [2:0] tag, input logic [31:0] data);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_data = data;
    step();
    idle_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    dbg_addr = '0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check(iss_ready == 1'b1, "R1 iss_ready", 32'(iss_ready), 1);
    check(disp_valid == 1'b0, "R1 disp_valid", 32'(disp_valid), 0);
    dbg_addr = 4'd5;
    #1;
    check(dbg_val == 0 && dbg_tag == 0, "R1 reg5", dbg_val, 0);

    // Vector walk: R4 R5 R6 R8 R9
    for (int k = 0; k < NV; k++) begin
      iss_valid = VEC[k].iv; iss_op = VEC[k].op; iss_dst = VEC[k].dst;
      iss_src_a = VEC[k].sa; iss_src_b = VEC[k].sb;
      cdb_valid = VEC[k].cv; cdb_tag = VEC[k].ct; cdb_data = {16'h0, VEC[k].cd};
      step();
      if (VEC[k].edv) begin
        check(disp_valid == 1'b1, "R8 disp_valid", 32'(disp_valid), 1);
        check(disp_tag == VEC[k].etag, "R8 disp_tag", 32'(disp_tag), 32'(VEC[k].etag));
        check(disp_op == VEC[k].eop, "R2 disp_op", 32'(disp_op), 32'(VEC[k].eop));
        check(disp_va == {16'h0, VEC[k].eva}, "R4/R5/R6 disp_va", disp_va, {16'h0, VEC[k].eva});
        check(disp_vb == {16'h0, VEC[k].evb}, "R4/R5/R6 disp_vb", disp_vb, {16'h0, VEC[k].evb});
      end else begin
        check(disp_valid == 1'b0, "R8 no dispatch", 32'(disp_valid), 0);
      end
    end
    idle_inputs();

    // Rename table after the walk: R7 writeback, R2 rename
    dbg_addr = 4'd1; #1;
    check(dbg_val == 32'h11 && dbg_tag == 0, "R7 reg1 written", dbg_val, 32'h11);
    dbg_addr = 4'd4; #1;
    check(dbg_val == 32'h22 && dbg_tag == 0, "R7 reg4 written", dbg_val, 32'h22);
    dbg_addr = 4'd7; #1;
    check(dbg_tag == 3'd3, "R2 reg7 renamed", 32'(dbg_tag), 3);
    dbg_addr = 4'd6; #1;
    check(dbg_tag == 3'd1, "R2 reg6 renamed to reused station", 32'(dbg_tag), 1);

    // WAW: two renames of register 8, older broadcast must not land (R7)
    do_reset();
    dbg_addr = 4'd8;
    issue(4'd5, 4'd8);
    check(dbg_tag == 3'd1, "R2 first rename", 32'(dbg_tag), 1);
    issue(4'd6, 4'd8);
    check(dbg_tag == 3'd2, "R2 second rename", 32'(dbg_tag), 2);
    broadcast(3'd1, 32'hAAAA);
    check(dbg_val == 0 && dbg_tag == 3'd2, "R7 stale broadcast ignored", dbg_val, 0);
    broadcast(3'd2, 32'hBBBB);
    check(dbg_val == 32'hBBBB && dbg_tag == 0, "R7 newest broadcast lands", dbg_val, 32'hBBBB);

    // Structural stall (R3) and release (R9)
    do_reset();
    for (int r = 9; r < 13; r++) issue(4'd1, 4'(r));
    check(iss_ready == 1'b0, "R3 full bank", 32'(iss_ready), 0);
    dbg_addr = 4'd13;
    issue(4'd2, 4'd13);
    check(dbg_tag == 0, "R3 ignored issue left rename", 32'(dbg_tag), 0);
    broadcast(3'd3, 32'h5);
    check(iss_ready == 1'b1, "R9 slot freed", 32'(iss_ready), 1);
    dbg_addr = 4'd14;
    issue(4'd2, 4'd14);
    check(dbg_tag == 3'd3, "R2/R9 freed station reused", 32'(dbg_tag), 3);
    check(iss_ready == 1'b0, "R3 full again", 32'(iss_ready), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule